// File: doc/BRIEF.md
# Clock Manager Health Monitor

This block supervises an on-chip clock manager made of a delay-locked loop and a frequency synthesizer. It samples the manager's lock output and its 8-bit status bus in a free-running reference clock domain. When it sees a fault, it drives a reset pulse of fixed length into the manager. It then ignores faults for a holdoff window while the manager restarts. After that it waits for lock to return, and only then reports the clock healthy again.

The following conditions count as faults:

- a delay-line overflow;
- a stopped input clock;
- a stopped synthesizer output, but only when a configuration input says the synthesized output is in use;
- a phase misalignment;
- loss of lock.

Each detected cause is ORed into a sticky register, which software clears through a dedicated input. A saturating counter records how many reset pulses have been issued. If lock never returns after a reset, a timeout starts another reset pulse.

Top module: `clkmgr_health_mon`

## Requirements
- R1: Status bit 0 (delay-line overflow) high while healthy starts a reset pulse and sets cause bit 0.
- R2: Status bit 1 (input clock stopped) high while healthy starts a reset pulse and sets cause bit 1.
- R3: Status bit 2 (synthesizer stopped) starts a reset pulse and sets cause bit 2 only when `synth_used` is 1. With `synth_used` at 0 it has no effect.
- R4: Status bit 7 (loop not in phase) high while healthy starts a reset pulse and sets cause bit 3.
- R5: `lock_in` low while healthy starts a reset pulse and sets cause bit 4.
- R6: Status bits 3 to 6 never cause a reset and never set a cause bit.
- R7: `cm_rst` stays high for exactly PULSE_CYC cycles. A holdoff of HOLDOFF_CYC cycles follows, and faults seen during the pulse or the holdoff start no further pulse.
- R8: After reset, `healthy`, `cm_rst`, `fault_cause` and `reset_count` are 0. `healthy` is 1 only when lock has been seen and no pulse or holdoff is in progress.
- R9: If lock does not return within LOCK_TIMEOUT cycles after the holdoff, another reset pulse is issued.
- R10: Cause bits are sticky until `cause_clr` is sampled high. A cause seen in the same cycle as the clear is kept.
- R11: `reset_count` increments once per reset pulse and saturates at 255.
- R12: Lock and status pass through a two-flop synchronizer. A fault present before a rising edge raises `cm_rst` after the third rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| lock_in | input | 1 | Lock output of the clock manager (asynchronous) |
| stat_in | input | 8 | Status bus of the clock manager (asynchronous) |
| synth_used | input | 1 | 1 when the synthesized output is in use |
| cause_clr | input | 1 | Clears the sticky cause register |
| cm_rst | output | 1 | Reset to the clock manager, active high |
| healthy | output | 1 | Clock is locked and no fault is being handled |
| fault_cause | output | 5 | Sticky causes: [0] overflow, [1] input stopped, [2] synthesizer stopped, [3] phase, [4] lock loss |
| reset_count | output | 8 | Saturating count of reset pulses issued |

## Verification
The assertions check the following on every cycle:

- `healthy` and `cm_rst` are never both high;
- a fault seen while healthy produces `cm_rst` on the next edge;
- a gated synthesizer-stop bit and a fault-free status keep the block healthy;
- cause bits never fall without a clear;
- the counter never goes down.

Some behaviours only the bench scenarios can show. These are the exact pulse length, the holdoff that absorbs a lingering fault, the relock timeout, the synchronizer latency, cause accumulation across several faults, and counter saturation after many retries.

// File: rtl/clkmgr_health_mon.sv
module clkmgr_health_mon #(
  parameter int PULSE_CYC    = 4,
  parameter int HOLDOFF_CYC  = 64,
  parameter int LOCK_TIMEOUT = 1024
) (
  input  logic       ref_clk,
  input  logic       arst_n,
  input  logic       lock_in,
  input  logic [7:0] stat_in,
  input  logic       synth_used,
  input  logic       cause_clr,
  output logic       cm_rst,
  output logic       healthy,
  output logic [4:0] fault_cause,
  output logic [7:0] reset_count
);

  localparam int MAXC = (LOCK_TIMEOUT > HOLDOFF_CYC)
                        ? ((LOCK_TIMEOUT > PULSE_CYC) ? LOCK_TIMEOUT : PULSE_CYC)
                        : ((HOLDOFF_CYC > PULSE_CYC) ? HOLDOFF_CYC : PULSE_CYC);
  localparam int CW = $clog2(MAXC) + 1;
  localparam logic [CW-1:0] PULSE_END = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] HOLD_END  = CW'(HOLDOFF_CYC - 1);
  localparam logic [CW-1:0] TMO_END   = CW'(LOCK_TIMEOUT - 1);

  typedef enum logic [1:0] {WAIT_LOCK, RUNNING, RESET_PULSE, HOLDOFF} mon_state_t;

  mon_state_t    state;
  logic [CW-1:0] cnt;
  logic [8:0]    sync1, sync2;
  logic          lock_s;
  logic [7:0]    stat_s;
  logic [4:0]    fault;

  always_ff @(posedge ref_clk or negedge arst_n)
    if (!arst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= {lock_in, stat_in};
      sync2 <= sync1;
    end

  assign lock_s = sync2[8];
  assign stat_s = sync2[7:0];
  assign fault  = {~lock_s, stat_s[7], stat_s[2] & synth_used, stat_s[1], stat_s[0]};

  assign cm_rst      = (state == RESET_PULSE);
  assign healthy     = (state == RUNNING);

  always_ff @(posedge ref_clk or negedge arst_n)
    if (!arst_n) begin
      state       <= WAIT_LOCK;
      cnt         <= '0;
      fault_cause <= '0;
      reset_count <= '0;
    end else begin
      cnt         <= cnt + 1'b1;
      fault_cause <= (cause_clr ? 5'b0 : fault_cause) | (healthy ? fault : 5'b0);
      unique case (state)
        WAIT_LOCK:
          if (lock_s) begin
            state <= RUNNING;
            cnt   <= '0;
          end else if (cnt == TMO_END) begin
            state <= RESET_PULSE;
            cnt   <= '0;
            if (reset_count != 8'hFF) reset_count <= reset_count + 1'b1;
          end
        RUNNING: begin
          cnt <= '0;
          if (|fault) begin
            state <= RESET_PULSE;
            if (reset_count != 8'hFF) reset_count <= reset_count + 1'b1;
          end
        end
        RESET_PULSE:
          if (cnt == PULSE_END) begin
            state <= HOLDOFF;
            cnt   <= '0;
          end
        HOLDOFF:
          if (cnt == HOLD_END) begin
            state <= WAIT_LOCK;
            cnt   <= '0;
          end
        default: state <= WAIT_LOCK;
      endcase
    end

  assert_exclusive_R8: assert property (@(posedge ref_clk) disable iff (!arst_n)
    !(healthy && cm_rst));

  // A fault caught while healthy is answered on the next edge (R1, R2, R4, R5)
  assert_fault_resets_R5: assert property (@(posedge ref_clk) disable iff (!arst_n)
    (healthy && (stat_s[0] || stat_s[1] || stat_s[7] || !lock_s)) |=> cm_rst);

  assert_synth_gated_R3: assert property (@(posedge ref_clk) disable iff (!arst_n)
    (healthy && lock_s && !synth_used && stat_s == 8'h04) |=> healthy);

  assert_upper_ignored_R6: assert property (@(posedge ref_clk) disable iff (!arst_n)
    (healthy && lock_s && !stat_s[0] && !stat_s[1] && !stat_s[2] && !stat_s[7]) |=> healthy);

  assert_cause_sticky_R10: assert property (@(posedge ref_clk) disable iff (!arst_n)
    !cause_clr |=> ((fault_cause & $past(fault_cause)) == $past(fault_cause)));

  assert_count_monotonic_R11: assert property (@(posedge ref_clk) disable iff (!arst_n)
    1'b1 |=> (reset_count >= $past(reset_count)));

  assert_healthy_needs_lock_R8: assert property (@(posedge ref_clk) disable iff (!arst_n)
    $rose(healthy) |-> $past(lock_s));

endmodule

// File: tb/clkmgr_health_mon_test.sv
module clkmgr_health_mon_test;
  logic       ref_clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       lock_in = 1'b1;
  logic [7:0] stat_in = 8'h00;
  logic       synth_used = 1'b0;
  logic       cause_clr = 1'b0;
  logic       cm_rst, healthy;
  logic [4:0] fault_cause;
  logic [7:0] reset_count;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 ref_clk = ~ref_clk;

  clkmgr_health_mon #(.PULSE_CYC(4), .HOLDOFF_CYC(8), .LOCK_TIMEOUT(32)) uut (
    .ref_clk(ref_clk), .arst_n(arst_n), .lock_in(lock_in), .stat_in(stat_in),
    .synth_used(synth_used), .cause_clr(cause_clr), .cm_rst(cm_rst),
    .healthy(healthy), .fault_cause(fault_cause), .reset_count(reset_count));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge ref_clk);
    @(negedge ref_clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic clear_cause;
    cause_clr = 1'b1;
    cyc(1);
    cause_clr = 1'b0;
  endtask

  // {status[14:7], synth_used[6], expect_reset[5], expect_cause[4:0]}
  localparam logic [14:0] VEC [0:7] = '{
    {8'h01, 1'b0, 1'b1, 5'b00001},
    {8'h02, 1'b0, 1'b1, 5'b00010},
    {8'h04, 1'b1, 1'b1, 5'b00100},
    {8'h80, 1'b0, 1'b1, 5'b01000},
    {8'h81, 1'b1, 1'b1, 5'b01001},
    {8'h84, 1'b1, 1'b1, 5'b01100},
    {8'h04, 1'b0, 1'b0, 5'b00000},
    {8'h78, 1'b1, 1'b0, 5'b00000}
  };

  initial begin
    repeat (200000) @(posedge ref_clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int w;
    int base;
    cyc(3);
    chk(!healthy && !cm_rst, "R8 reset outputs", {healthy, cm_rst}, 0);
    chk(fault_cause == 0 && reset_count == 0, "R8 reset regs", fault_cause + reset_count, 0);
    arst_n = 1'b1;
    cyc(5);
    chk(healthy == 1'b1, "R8 healthy after lock", healthy, 1);

    for (int v = 0; v < 8; v++) begin
      stat_in    = VEC[v][14:7];
      synth_used = VEC[v][6];
      cyc(2);
      chk(cm_rst == 1'b0, "R12 no reset before third edge", cm_rst, 0);
      cyc(1);
      chk(cm_rst == VEC[v][5], $sformatf("R1/R2/R3/R4/R6 reset vec %0d", v), cm_rst, VEC[v][5]);
      chk(fault_cause == VEC[v][4:0], $sformatf("R1/R2/R3/R4/R6 cause vec %0d", v),
          fault_cause, VEC[v][4:0]);
      if (VEC[v][5]) begin
        w = 0;
        while (cm_rst && w < 100) begin
          w++;
          cyc(1);
        end
        chk(w == 4, "R7 pulse width", w, 4);
        stat_in = 8'h00;
        clear_cause();
        chk(fault_cause == 0, "R10 clear", fault_cause, 0);
        cyc(12);
      end else begin
        stat_in = 8'h00;
        cyc(3);
      end
      chk(healthy == 1'b1, $sformatf("R8 healthy after vec %0d", v), healthy, 1);
    end
    chk(reset_count == 6, "R7 R11 one pulse per fault despite holdoff", reset_count, 6);

    // sticky accumulation
    stat_in = 8'h01;
    cyc(3);
    stat_in = 8'h00;
    cyc(20);
    stat_in = 8'h02;
    cyc(3);
    stat_in = 8'h00;
    chk(fault_cause == 5'b00011, "R10 sticky accumulate", fault_cause, 3);
    cyc(20);
    clear_cause();
    chk(reset_count == 8, "R11 count", reset_count, 8);

    // lock loss and relock timeout
    base = reset_count;
    lock_in = 1'b0;
    cyc(3);
    chk(cm_rst == 1'b1, "R5 lock loss reset", cm_rst, 1);
    chk(fault_cause == 5'b10000, "R5 lock loss cause", fault_cause, 16);
    cyc(50);
    chk(reset_count == base + 2, "R9 timeout retry", reset_count, base + 2);
    chk(healthy == 1'b0, "R8 not healthy without lock", healthy, 0);
    lock_in = 1'b1;
    cyc(60);
    chk(healthy == 1'b1, "R9 recovery after lock", healthy, 1);
    clear_cause();

    // saturation
    lock_in = 1'b0;
    for (int k = 0; k < 20000 && reset_count != 8'hFF; k++) cyc(1);
    cyc(200);
    chk(reset_count == 8'hFF, "R11 saturate", reset_count, 255);
    chk(healthy == 1'b0, "R8 unhealthy while unlocked", healthy, 0);
    finish_run();
  end
endmodule